// File: doc/BRIEF.md
# Command Block Register Sequencer

This block executes one in-memory command block for a disk-style device port. A start pulse, together with the block's base address, makes it fetch the block one 64-bit word at a time through a read port that allows one request in flight. It then checks the header and replays the embedded list of register writes onto the device register-write port. When the command carries a data phase, it passes the first data-descriptor pointer to a scatter-gather walker. Once the device reports the command finished, it writes a response byte back into byte 0 of the block.

A block holds 8-byte words, stored little-endian (byte k of a word sits in bits 8k+7..8k). Word 0 carries the response byte (byte 0), the control flags (byte 2: bit 0 valid, bit 2 data phase, bit 3 interrupt on completion), the list length (byte 3) and a link address that this block does not use. Word 1 carries the descriptor pointer in bytes 8–11. The register list starts at word 2. The length byte counts the list in whole words, so the descriptor area starts at byte (2 + length) × 8.

Top module: `cpbseq_top`

## Requirements
- R1: While reset is held, and in the first cycle after reset, every strobe output (rd_req_o, reg_we_o, prd_start_o, wb_en_o, done_o, irq_o, fault_o) is low.
- R2: A start pulse seen while idle leads, in the next cycle, to a one-cycle read request for the word at the start address. The second word is requested at address + 8 and list word n at address + 8·n. Each request is made only in the cycle after the response to the previous one has been taken, and at most one is outstanding.
- R3: If bit 0 of byte 2 of the first word is clear, the cycle after that word arrives shows fault_o for one cycle. No further read, register write, descriptor start or write-back follows.
- R4: If the length byte is 0 or larger than LIST_WORDS_MAX, the cycle after the second word arrives shows fault_o for one cycle. No list word is read and nothing is written.
- R5: Each list word holds four pairs, taken in rising byte order. Pair p has its value in byte 2p and its address byte in byte 2p+1. The cycle after a list word arrives starts pair 0, and each pair takes exactly one cycle. A pair with address bit 5 clear drives reg_we_o for that cycle, with reg_data_o set to the value and reg_addr_o set to the whole address byte.
- R6: A pair whose address byte has bit 5 set produces no register write but still takes its cycle.
- R7: A pair whose address byte has bit 7 set is the final pair. The pairs after it in the same word are ignored and no further word is read.
- R8: If the fourth pair of list word number `length` (the last one allowed) does not carry bit 7, fault_o is raised for one cycle in the next cycle. There is no descriptor start and no write-back.
- R9: When flag bit 2 is set, prd_start_o pulses for one cycle in the cycle after the final pair, with prd_ptr_o equal to bytes 8–11 of the block. When the bit is clear, no pulse appears.
- R10: After the final pair (and the descriptor start, if any), the block waits for cmd_end_i. In the cycle after that input is seen, done_o and wb_en_o pulse together, with wb_addr_o equal to the block address. wb_byte_o is 0x01, or 0x09 when cmd_err_i was high together with cmd_end_i.
- R11: irq_o pulses with done_o exactly when flag bit 3 of the block is set.
- R12: A start pulse arriving while a block is in progress is ignored: the addresses of later requests still follow the original block address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for one block |
| cpb_addr_i | input | ADDR_W | Byte address of the block, taken with start_i |
| rd_req_o | output | 1 | One-cycle word read request |
| rd_addr_o | output | ADDR_W | Address of the requested word |
| rd_valid_i | input | 1 | Read response strobe |
| rd_data_i | input | 64 | Read response word, little-endian |
| reg_we_o | output | 1 | Device register write strobe |
| reg_addr_o | output | 8 | Address byte of the pair (register code in bits 4:0) |
| reg_data_o | output | 8 | Value written to the device register |
| prd_start_o | output | 1 | Starts the scatter-gather walker |
| prd_ptr_o | output | 32 | First data-descriptor address |
| cmd_end_i | input | 1 | Device reports command completion |
| cmd_err_i | input | 1 | Device error, taken with cmd_end_i |
| wb_en_o | output | 1 | Response byte write strobe |
| wb_addr_o | output | ADDR_W | Address of the response byte |
| wb_byte_o | output | 8 | Response byte value |
| done_o | output | 1 | Block completed |
| irq_o | output | 1 | Completion interrupt request |
| fault_o | output | 1 | Packet-sequence fault |

## Verification
The bench builds the block with a 32-bit address and LIST_WORDS_MAX set to 4. A five-word list is then enough to cross the length limit, and a list that runs out without an end flag reaches the last-word fault after only four words of stimulus. Memory latency of zero, one and two cycles exercises the one-request-in-flight rule. A 48-bit command filling three list words shows the high-order bytes going out before the low-order ones.

// File: rtl/cpbseq_pkg.sv
package cpbseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_REPLAY,
        ST_KICK,
        ST_HOLD,
        ST_FINISH,
        ST_FAULT
    } seq_st_e;

    // block word geometry
    localparam int unsigned BLK_WORD_BYTES = 8;
    localparam int unsigned BLK_WORD_BITS  = BLK_WORD_BYTES * 8;
    localparam int unsigned PAIRS_PER_WORD = BLK_WORD_BYTES / 2;
    localparam int unsigned PTR_BITS       = 32;

    // header byte positions inside word 0
    localparam int unsigned HDR_FLAG_BYTE = 2;
    localparam int unsigned HDR_LEN_BYTE  = 3;

    // control flag bits
    localparam int unsigned FLG_VALID = 0;
    localparam int unsigned FLG_DATA  = 2;
    localparam int unsigned FLG_IRQ   = 3;

    // flag bits inside a pair's address byte
    localparam int unsigned RA_SKIP = 5;
    localparam int unsigned RA_LAST = 7;

    // response byte
    localparam logic [7:0]  RESP_OK     = 8'h01;
    localparam int unsigned RESP_DEVERR = 3;

endpackage

// File: rtl/cpbseq_pair_pick.sv
module cpbseq_pair_pick
    import cpbseq_pkg::*;
#(
    parameter int unsigned PAIRS = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic [PAIRS*16-1:0] word_i,
    input  logic [IDX_W-1:0]    idx_i,
    output logic [7:0]          val_o,
    output logic [7:0]          ra_o,
    output logic                skip_o,
    output logic                last_o
);

    logic [7:0] vals [PAIRS];
    logic [7:0] ras  [PAIRS];

    // split the word into value / address byte lanes
    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        assign vals[g] = word_i[16*g +: 8];
        assign ras[g]  = word_i[16*g + 8 +: 8];
    end

    always_comb begin
        val_o = vals[idx_i];
        ra_o  = ras[idx_i];
    end

    assign skip_o = ra_o[RA_SKIP];
    assign last_o = ra_o[RA_LAST];

endmodule

// File: rtl/cpbseq_len_check.sv
module cpbseq_len_check #(
    parameter int unsigned LIST_MAX = 16,
    parameter int unsigned WC_W     = 5
) (
    input  logic [7:0]      len_i,
    input  logic [WC_W-1:0] wc_i,
    output logic            len_ok_o,
    output logic            last_word_o
);

    // list words sit at word numbers 2 .. len+1
    assign len_ok_o    = (len_i != 8'd0) && (32'(len_i) <= LIST_MAX);
    assign last_word_o = (32'(wc_i) == (32'(len_i) + 32'd1));

endmodule

// File: rtl/cpbseq_top.sv
module cpbseq_top
    import cpbseq_pkg::*;
#(
    parameter int unsigned ADDR_W         = 32,
    parameter int unsigned LIST_WORDS_MAX = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [ADDR_W-1:0]        cpb_addr_i,
    output logic                     rd_req_o,
    output logic [ADDR_W-1:0]        rd_addr_o,
    input  logic                     rd_valid_i,
    input  logic [BLK_WORD_BITS-1:0] rd_data_i,
    output logic                     reg_we_o,
    output logic [7:0]               reg_addr_o,
    output logic [7:0]               reg_data_o,
    output logic                     prd_start_o,
    output logic [PTR_BITS-1:0]      prd_ptr_o,
    input  logic                     cmd_end_i,
    input  logic                     cmd_err_i,
    output logic                     wb_en_o,
    output logic [ADDR_W-1:0]        wb_addr_o,
    output logic [7:0]               wb_byte_o,
    output logic                     done_o,
    output logic                     irq_o,
    output logic                     fault_o
);

    localparam int unsigned WC_W    = $clog2(LIST_WORDS_MAX + 2);
    localparam int unsigned IDX_W   = $clog2(PAIRS_PER_WORD);
    localparam int unsigned BYTE_SH = $clog2(BLK_WORD_BYTES);

    typedef struct packed {
        seq_st_e                  st;
        logic [ADDR_W-1:0]        base;
        logic [WC_W-1:0]          wc;
        logic [7:0]               len;
        logic                     dat;
        logic                     ien;
        logic [PTR_BITS-1:0]      ptr;
        logic [BLK_WORD_BITS-1:0] word;
        logic [IDX_W-1:0]         idx;
        logic                     err;
    } seq_t;

    seq_t q, d;

    logic [7:0] pick_val, pick_ra;
    logic       pick_skip, pick_last;
    logic       len_ok, last_word;

    cpbseq_pair_pick #(
        .PAIRS (PAIRS_PER_WORD),
        .IDX_W (IDX_W)
    ) u_pick (
        .word_i (q.word),
        .idx_i  (q.idx),
        .val_o  (pick_val),
        .ra_o   (pick_ra),
        .skip_o (pick_skip),
        .last_o (pick_last)
    );

    cpbseq_len_check #(
        .LIST_MAX (LIST_WORDS_MAX),
        .WC_W     (WC_W)
    ) u_len (
        .len_i       (q.len),
        .wc_i        (q.wc),
        .len_ok_o    (len_ok),
        .last_word_o (last_word)
    );

    // next-state logic
    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.base = cpb_addr_i;
                    d.wc   = '0;
                    d.err  = 1'b0;
                    d.st   = ST_REQ;
                end
            end
            ST_REQ: d.st = ST_WAIT;
            ST_WAIT: begin
                if (rd_valid_i) begin
                    if (q.wc == WC_W'(0)) begin
                        d.dat = rd_data_i[HDR_FLAG_BYTE*8 + FLG_DATA];
                        d.ien = rd_data_i[HDR_FLAG_BYTE*8 + FLG_IRQ];
                        d.len = rd_data_i[HDR_LEN_BYTE*8 +: 8];
                        if (!rd_data_i[HDR_FLAG_BYTE*8 + FLG_VALID]) begin
                            d.st = ST_FAULT;
                        end else begin
                            d.wc = WC_W'(1);
                            d.st = ST_REQ;
                        end
                    end else if (q.wc == WC_W'(1)) begin
                        d.ptr = rd_data_i[PTR_BITS-1:0];
                        if (!len_ok) begin
                            d.st = ST_FAULT;
                        end else begin
                            d.wc = WC_W'(2);
                            d.st = ST_REQ;
                        end
                    end else begin
                        d.word = rd_data_i;
                        d.idx  = '0;
                        d.st   = ST_REPLAY;
                    end
                end
            end
            ST_REPLAY: begin
                if (pick_last) begin
                    d.st = q.dat ? ST_KICK : ST_HOLD;
                end else if (q.idx == IDX_W'(PAIRS_PER_WORD - 1)) begin
                    if (last_word) begin
                        d.st = ST_FAULT;
                    end else begin
                        d.wc = q.wc + WC_W'(1);
                        d.st = ST_REQ;
                    end
                end else begin
                    d.idx = q.idx + IDX_W'(1);
                end
            end
            ST_KICK: d.st = ST_HOLD;
            ST_HOLD: begin
                if (cmd_end_i) begin
                    d.err = cmd_err_i;
                    d.st  = ST_FINISH;
                end
            end
            ST_FINISH: d.st = ST_IDLE;
            ST_FAULT:  d.st = ST_IDLE;
            default:   d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // outputs decoded from registered state
    assign rd_req_o    = (q.st == ST_REQ);
    assign rd_addr_o   = q.base + ADDR_W'({q.wc, {BYTE_SH{1'b0}}});
    assign reg_we_o    = (q.st == ST_REPLAY) && !pick_skip;
    assign reg_addr_o  = pick_ra;
    assign reg_data_o  = pick_val;
    assign prd_start_o = (q.st == ST_KICK);
    assign prd_ptr_o   = q.ptr;
    assign done_o      = (q.st == ST_FINISH);
    assign wb_en_o     = (q.st == ST_FINISH);
    assign wb_addr_o   = q.base;
    assign wb_byte_o   = RESP_OK | (8'(q.err) << RESP_DEVERR);
    assign irq_o       = (q.st == ST_FINISH) && q.ien;
    assign fault_o     = (q.st == ST_FAULT);

    // R2: a request never lasts past one cycle
    a_r2_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);

    // R5: at most one externally visible event per cycle
    a_r5_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req_o, reg_we_o, prd_start_o, done_o, fault_o}));

    // R9: walker start only right after the final pair
    a_r9_kick_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        prd_start_o |-> $past(q.st == ST_REPLAY && pick_last));

    // R10: response byte is done, optionally with the device-error bit
    a_r10_resp_code: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (wb_byte_o == 8'h01 || wb_byte_o == 8'h09));

    // R12: block address held while busy
    a_r12_base_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> $stable(q.base));

endmodule

// File: tb/tb_cpbseq_top.sv
`timescale 1ns/1ps
module tb_cpbseq_top;

    localparam int unsigned AW   = 32;
    localparam int unsigned LMAX = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic           start_i = 1'b0;
    logic [AW-1:0]  cpb_addr_i = '0;
    logic           rd_req_o;
    logic [AW-1:0]  rd_addr_o;
    logic           rd_valid_i = 1'b0;
    logic [63:0]    rd_data_i = '0;
    logic           reg_we_o;
    logic [7:0]     reg_addr_o, reg_data_o;
    logic           prd_start_o;
    logic [31:0]    prd_ptr_o;
    logic           cmd_end_i = 1'b0, cmd_err_i = 1'b0;
    logic           wb_en_o;
    logic [AW-1:0]  wb_addr_o;
    logic [7:0]     wb_byte_o;
    logic           done_o, irq_o, fault_o;

    cpbseq_top #(.ADDR_W(AW), .LIST_WORDS_MAX(LMAX)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cpb_addr_i(cpb_addr_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
        .rd_data_i(rd_data_i), .reg_we_o(reg_we_o), .reg_addr_o(reg_addr_o),
        .reg_data_o(reg_data_o), .prd_start_o(prd_start_o), .prd_ptr_o(prd_ptr_o),
        .cmd_end_i(cmd_end_i), .cmd_err_i(cmd_err_i), .wb_en_o(wb_en_o),
        .wb_addr_o(wb_addr_o), .wb_byte_o(wb_byte_o), .done_o(done_o),
        .irq_o(irq_o), .fault_o(fault_o)
    );

    typedef struct packed {
        logic        req;
        logic [31:0] addr;
        logic        we;
        logic [7:0]  ra;
        logic [7:0]  rv;
        logic        kick;
        logic [31:0] ptr;
        logic        done;
        logic [7:0]  wb;
        logic        irq;
        logic        fault;
    } exp_t;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;
    bit poke = 0;
    logic [31:0] cur_base = '0;
    logic [63:0] mem [0:7];

    task automatic chk(input exp_t e, input string tag);
        bit bad = 0;
        vectors++;
        if (rd_req_o !== e.req) bad = 1;
        if (e.req && rd_addr_o !== e.addr) bad = 1;
        if (reg_we_o !== e.we) bad = 1;
        if (e.we && (reg_addr_o !== e.ra || reg_data_o !== e.rv)) bad = 1;
        if (prd_start_o !== e.kick) bad = 1;
        if (e.kick && prd_ptr_o !== e.ptr) bad = 1;
        if (done_o !== e.done || wb_en_o !== e.done) bad = 1;
        if (e.done && (wb_byte_o !== e.wb || wb_addr_o !== cur_base)) bad = 1;
        if (irq_o !== e.irq || fault_o !== e.fault) bad = 1;
        if (bad) begin
            miscompares++;
            $display("FAIL %s: actual req=%b addr=%h we=%b ra=%h rv=%h kick=%b ptr=%h done=%b wb=%h irq=%b fault=%b | expected req=%b addr=%h we=%b ra=%h rv=%h kick=%b ptr=%h done=%b wb=%h irq=%b fault=%b",
                     tag, rd_req_o, rd_addr_o, reg_we_o, reg_addr_o, reg_data_o,
                     prd_start_o, prd_ptr_o, done_o, wb_byte_o, irq_o, fault_o,
                     e.req, e.addr, e.we, e.ra, e.rv, e.kick, e.ptr, e.done, e.wb,
                     e.irq, e.fault);
        end
    endtask

    task automatic step();
        @(negedge clk);
        rd_valid_i = 1'b0;
        cmd_end_i  = 1'b0;
        start_i    = 1'b0;
    endtask

    task automatic wait_resp(input int lat, input logic [63:0] data, input string tag);
        for (int d = 0; d <= lat; d++) begin
            step();
            chk('0, tag);
            if (poke && d == 0) begin
                start_i    = 1'b1;
                cpb_addr_i = 32'hDEAD_0000;
            end
            if (d == lat) begin
                rd_valid_i = 1'b1;
                rd_data_i  = data;
            end
        end
    endtask

    function automatic logic [63:0] hdr0(input logic [7:0] flags, input logic [7:0] len);
        return {32'h0000_1000, len, flags, 8'h00, 8'h00};
    endfunction

    function automatic logic [63:0] prs(input logic [7:0] v0, a0, v1, a1, v2, a2, v3, a3);
        return {a3, v3, a2, v2, a1, v1, a0, v0};
    endfunction

    // behavioural model of one block, cycle by cycle
    task automatic run_cpb(input logic [31:0] base, input int lat, input int hold, input logic derr);
        exp_t e;
        logic [7:0] flags, len;
        logic [31:0] ptr;
        int w;
        bit ended;
        cur_base = base;
        step();
        chk('0, "R1");
        start_i    = 1'b1;
        cpb_addr_i = base;
        step();
        e = '0; e.req = 1'b1; e.addr = base; chk(e, "R2");
        wait_resp(lat, mem[0], "R2");
        flags = mem[0][23:16];
        len   = mem[0][31:24];
        step();
        if (!flags[0]) begin
            e = '0; e.fault = 1'b1; chk(e, "R3");
            step(); chk('0, "R3");
            return;
        end
        e = '0; e.req = 1'b1; e.addr = base + 32'd8; chk(e, "R2");
        wait_resp(lat, mem[1], poke ? "R12" : "R2");
        ptr = mem[1][31:0];
        step();
        if (len == 8'd0 || 32'(len) > LMAX) begin
            e = '0; e.fault = 1'b1; chk(e, "R4");
            step(); chk('0, "R4");
            return;
        end
        w = 2;
        ended = 0;
        while (!ended) begin
            e = '0; e.req = 1'b1; e.addr = base + 32'(8 * w);
            chk(e, poke ? "R12" : "R2");
            wait_resp(lat, mem[w], "R2");
            for (int p = 0; p < 4; p++) begin
                logic [7:0] v, a;
                step();
                v = mem[w][16*p +: 8];
                a = mem[w][16*p + 8 +: 8];
                e = '0; e.we = !a[5]; e.ra = a; e.rv = v;
                chk(e, a[5] ? "R6" : "R5");
                if (a[7]) begin
                    ended = 1;
                    break;
                end
            end
            if (!ended) begin
                step();
                if (w == int'(len) + 1) begin
                    e = '0; e.fault = 1'b1; chk(e, "R8");
                    step(); chk('0, "R8");
                    return;
                end
                w++;
            end
        end
        if (flags[2]) begin
            step();
            e = '0; e.kick = 1'b1; e.ptr = ptr; chk(e, "R9");
        end
        for (int h = 0; h <= hold; h++) begin
            step();
            chk('0, "R10");
            if (h == hold) begin
                cmd_end_i = 1'b1;
                cmd_err_i = derr;
            end
        end
        step();
        e = '0; e.done = 1'b1; e.wb = derr ? 8'h09 : 8'h01; e.irq = flags[3];
        chk(e, flags[3] ? "R11" : "R10");
        step();
        chk('0, "R7");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk('0, "R1");
        rst_n = 1'b1;
        step();
        chk('0, "R1");

        // 28-bit command, data phase, interrupt, zero latency
        mem[0] = hdr0(8'h0D, 8'd2);
        mem[1] = {32'h0, 32'h0000_2400};
        mem[2] = prs(8'hE0, 8'h16, 8'h08, 8'h12, 8'h11, 8'h13, 8'h22, 8'h14);
        mem[3] = prs(8'h33, 8'h15, 8'h00, 8'h0E, 8'h00, 8'h20, 8'hC8, 8'h97);
        run_cpb(32'h0000_0100, 0, 2, 1'b0);

        // 48-bit command over three list words, latency 2, device error, busy start
        mem[0] = hdr0(8'h05, 8'd3);
        mem[1] = {32'h0, 32'h0000_3800};
        mem[2] = prs(8'hE0, 8'h16, 8'h00, 8'h12, 8'h01, 8'h13, 8'h02, 8'h14);
        mem[3] = prs(8'h03, 8'h15, 8'h10, 8'h12, 8'h44, 8'h13, 8'h55, 8'h14);
        mem[4] = prs(8'h66, 8'h15, 8'h00, 8'h0E, 8'h00, 8'h20, 8'h25, 8'h97);
        poke = 1;
        run_cpb(32'h0000_0200, 2, 0, 1'b1);
        poke = 0;

        // early end inside first word, no data phase, interrupt
        mem[0] = hdr0(8'h09, 8'd1);
        mem[1] = {32'h0, 32'h0000_4000};
        mem[2] = prs(8'hA0, 8'h16, 8'hEC, 8'h97, 8'h77, 8'h12, 8'h88, 8'h13);
        run_cpb(32'h0000_0300, 1, 0, 1'b0);

        // end pair that is also skipped
        mem[0] = hdr0(8'h05, 8'd1);
        mem[1] = {32'h0, 32'h0000_5000};
        mem[2] = prs(8'hE0, 8'h16, 8'hCA, 8'h17, 8'h00, 8'h20, 8'h00, 8'hA0);
        run_cpb(32'h0000_0400, 0, 1, 1'b0);

        // valid flag clear
        mem[0] = hdr0(8'h0C, 8'd1);
        run_cpb(32'h0000_0500, 0, 0, 1'b0);

        // zero length
        mem[0] = hdr0(8'h05, 8'd0);
        run_cpb(32'h0000_0600, 1, 0, 1'b0);

        // length above limit
        mem[0] = hdr0(8'h05, 8'd5);
        run_cpb(32'h0000_0700, 0, 0, 1'b0);

        // list runs out without an end flag
        mem[0] = hdr0(8'h01, 8'd1);
        mem[2] = prs(8'hE0, 8'h16, 8'h00, 8'h12, 8'h00, 8'h20, 8'hEC, 8'h17);
        run_cpb(32'h0000_0800, 0, 0, 1'b0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule